// File: doc/BRIEF.md
# Bus-Attached Serial Port with Programmable Bit Rate

This block is a byte-wide asynchronous serial transmitter and receiver that a processor reaches as an APB slave. Software sets a bit-rate divisor, turns the port on, and then writes a byte to the transmit offset. That write starts the frame on the serial output at once, with no separate start command. The receiver watches the serial input all the time the port is enabled. Each good frame it decodes replaces the byte held in the receive register, with no software handshake. The line format is fixed: one low start bit, eight data bits sent least significant first, and one high stop bit. The output rests high when no frame is being sent.

Both serial engines are built around small state machines with the states IDLE, START, DATA and STOP. The transmitter moves IDLE→START when a transmit write is accepted. It moves START→DATA at the end of the start bit, stays in DATA for each of the eight bits, moves DATA→STOP after the last data bit, and moves STOP→IDLE at the end of the stop bit. The receiver moves IDLE→START when it sees a low line. At half a bit it either moves START→DATA, if the line is still low, or START→IDLE if it is not. It then samples each data bit at its centre while in DATA, moves DATA→STOP after the eighth bit, and moves STOP→IDLE at the centre of the stop bit, keeping the byte only if that stop bit is high. Any state goes to IDLE while the port is disabled.

Top module: `apb_uart`

## Requirements
- R1: After the asynchronous active-high reset, the serial output is high, PREADY is low, and the control, divisor, transmit and receive offsets all read zero.
- R2: Every transfer has exactly one wait state. PREADY goes high for one cycle, on the clock edge after the first cycle in which PSEL and PENABLE are both high. On that same edge a write takes effect and read data is presented on PRDATA.
- R3: PADDR bits [4:2] select the register: 0 is control, 1 is divisor, 2 is transmit, 3 is receive. All other address bits are ignored. The transmit offset reads as zero.
- R4: In the control register, bit 0 is the enable bit and can be read and written. Bit 1 reads as the transmitter-busy flag and cannot be written. All other bits read zero.
- R5: The divisor register keeps the low 16 bits of the written value and reads them back. Each serial bit lasts that many clocks.
- R6: A transmit write while the port is enabled and idle starts a frame on the write's clock edge. The frame is a low start bit, data bits 0 through 7, then a high stop bit.
- R7: A transmit write while a frame is in progress is discarded. The frame in progress is unchanged and no second frame follows.
- R8: While enable is 0, transmit writes start nothing and the serial output stays high. The receiver ignores the line and the receive register keeps its value. Clearing enable sends both engines back to IDLE.
- R9: Once a start edge is confirmed, the receiver samples each data bit at its centre. A frame whose stop bit is high writes its byte, zero-extended, into the receive register.
- R10: A low pulse on the input that has ended before half a bit time is rejected as a false start. It leaves the receive register unchanged, and the next frame is still received.
- R11: A frame whose stop bit samples low is discarded and the receive register is unchanged.
- R12: Reads of offsets 4 to 7 return zero. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and serial clock |
| prst | input | 1 | Asynchronous reset, active high |
| paddr | input | 32 | Transfer address |
| pwrite | input | 1 | 1 for write, 0 for read |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase indicator |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while pready is high |
| pready | output | 1 | Transfer completion, one-cycle pulse |
| uart_rxd | input | 1 | Serial input |
| uart_txd | output | 1 | Serial output, high when idle |

## Verification
The bench writes a byte to the transmit offset while a frame is already being sent. A design that accepted that write would corrupt the frame or send an unexpected second frame, and the serial scoreboard would flag it. Both the divisor value and the data pattern change between frames, including all-zeros and all-ones bytes; a design that counted the bit period off by one or shifted from the wrong end would lose alignment with the decoder. On the receive side the bench drives a short low glitch, a frame with a bad stop bit, and a frame sent while the port is disabled. A receiver that skipped the half-bit confirmation, ignored the stop bit, or kept running while disabled would overwrite the receive register in one of those cases. Aliased and unmapped addresses are also exercised, and a decoder that used too many or too few address bits would return the wrong register or non-zero data.

// File: rtl/apb_uart_pkg.sv
package apb_uart_pkg;

    // Register select field inside the bus address
    localparam int IDX_LSB = 2;
    localparam int IDX_W   = 3;

    typedef enum logic [IDX_W-1:0] {
        REG_CTRL = 3'd0,
        REG_DIV  = 3'd1,
        REG_TXD  = 3'd2,
        REG_RXD  = 3'd3
    } reg_idx_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/apb_uart_regs.sv
module apb_uart_regs
    import apb_uart_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              pwrite,
    input  logic              psel,
    input  logic              penable,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              enable,
    output logic [DIV_W-1:0]  divisor,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_busy,
    input  logic [BYTE_W-1:0] rx_byte
);

    logic              access;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rd_mux;

    // first access cycle only: pready high marks the completing cycle
    assign access  = psel & penable & ~pready;
    assign idx     = paddr[IDX_LSB +: IDX_W];
    assign tx_load = access & pwrite & (idx == REG_TXD) & enable & ~tx_busy;
    assign tx_byte = pwdata[BYTE_W-1:0];

    always_comb begin
        rd_mux = '0;
        case (idx)
            REG_CTRL: begin
                rd_mux[0] = enable;
                rd_mux[1] = tx_busy;
            end
            REG_DIV: rd_mux[DIV_W-1:0]  = divisor;
            REG_RXD: rd_mux[BYTE_W-1:0] = rx_byte;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            pready  <= 1'b0;
            prdata  <= '0;
            enable  <= 1'b0;
            divisor <= '0;
        end else begin
            pready <= access;
            if (access && pwrite) begin
                case (idx)
                    REG_CTRL: enable  <= pwdata[0];
                    REG_DIV:  divisor <= pwdata[DIV_W-1:0];
                    default:  ;
                endcase
            end
            if (access && !pwrite) begin
                prdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import apb_uart_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              load,
    input  logic [BYTE_W-1:0] data_in,
    output logic              txd,
    output logic              busy
);

    localparam int BIT_CW = $clog2(BYTE_W);

    tx_state_e         state;
    logic [DIV_W-1:0]  cnt;
    logic [BIT_CW-1:0] bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic              bit_end;

    assign bit_end = (({1'b0, cnt} + 1'b1) >= {1'b0, divisor});

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state   <= TX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else if (!enable) begin
            state   <= TX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (load) begin
                        state <= TX_START;
                        cnt   <= '0;
                        shreg <= data_in;
                    end
                end
                TX_START: begin
                    if (bit_end) begin
                        state   <= TX_DATA;
                        cnt     <= '0;
                        bit_idx <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        cnt   <= '0;
                        shreg <= shreg >> 1;
                        if (bit_idx == BIT_CW'(BYTE_W - 1)) begin
                            state <= TX_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TX_STOP: begin
                    if (bit_end) begin
                        state <= TX_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (state)
            TX_IDLE:  begin txd = 1'b1;     busy = 1'b0; end
            TX_START: begin txd = 1'b0;     busy = 1'b1; end
            TX_DATA:  begin txd = shreg[0]; busy = 1'b1; end
            TX_STOP:  begin txd = 1'b1;     busy = 1'b1; end
        endcase
    end

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import apb_uart_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              rxd,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam int BIT_CW = $clog2(BYTE_W);

    rx_state_e         state;
    logic [SYNC_N-1:0] sync;
    logic              rx_s;
    logic [DIV_W-1:0]  cnt;
    logic [BIT_CW-1:0] bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic              bit_end;
    logic              mid_end;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) sync <= '1;
        else     sync <= {sync[SYNC_N-2:0], rxd};
    end

    always_comb begin
        rx_s    = sync[SYNC_N-1];
        bit_end = (({1'b0, cnt} + 1'b1) >= {1'b0, divisor});
        mid_end = (({1'b0, cnt} + 1'b1) >= {2'b0, divisor[DIV_W-1:1]});
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            rx_byte <= '0;
        end else if (!enable) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    if (!rx_s) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (mid_end) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (bit_end) begin
                        cnt   <= '0;
                        shreg <= {rx_s, shreg[BYTE_W-1:1]};
                        if (bit_idx == BIT_CW'(BYTE_W - 1)) begin
                            state <= RX_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (bit_end) begin
                        state <= RX_IDLE;
                        cnt   <= '0;
                        if (rx_s) rx_byte <= shreg;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/apb_uart.sv
module apb_uart
    import apb_uart_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              pclk,
    input  logic              prst,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              pwrite,
    input  logic              psel,
    input  logic              penable,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic              uart_rxd,
    output logic              uart_txd
);

    logic              enable;
    logic [DIV_W-1:0]  divisor;
    logic              tx_load;
    logic [BYTE_W-1:0] tx_byte;
    logic              tx_busy;
    logic [BYTE_W-1:0] rx_byte;

    apb_uart_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .BYTE_W(BYTE_W)
    ) u_regs (
        .clk(pclk), .rst(prst),
        .paddr(paddr), .pwrite(pwrite), .psel(psel), .penable(penable),
        .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .enable(enable), .divisor(divisor),
        .tx_load(tx_load), .tx_byte(tx_byte),
        .tx_busy(tx_busy), .rx_byte(rx_byte)
    );

    uart_tx_fsm #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_tx (
        .clk(pclk), .rst(prst), .enable(enable), .divisor(divisor),
        .load(tx_load), .data_in(tx_byte), .txd(uart_txd), .busy(tx_busy)
    );

    uart_rx_fsm #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .SYNC_N(2)) u_rx (
        .clk(pclk), .rst(prst), .enable(enable), .divisor(divisor),
        .rxd(uart_rxd), .rx_byte(rx_byte)
    );

endmodule

// File: rtl/apb_uart_chk.sv
module apb_uart_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] prdata,
    input logic              pready,
    input logic              txd,
    input logic              enable,
    input logic              tx_busy,
    input logic [BYTE_W-1:0] rx_byte
);

    localparam int HI_IDX = apb_uart_pkg::IDX_LSB + apb_uart_pkg::IDX_W - 1;

    // R2
    pready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pready |=> !pready);

    // R2
    pready_after_access_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pready) |-> $past(psel && penable));

    // R12
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(pready) && $past(!pwrite && paddr[HI_IDX])) |-> (prdata == '0));

    // R6
    frame_starts_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> !txd);

    // R6
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);

    // R8
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !tx_busy);

    // R8
    rx_hold_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!enable) |-> $stable(rx_byte));

endmodule

bind apb_uart apb_uart_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)
) u_chk (
    .clk(pclk), .rst(prst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .prdata(prdata), .pready(pready), .txd(uart_txd),
    .enable(enable), .tx_busy(tx_busy), .rx_byte(rx_byte)
);

// File: tb/apb_uart_test.sv
module apb_uart_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] paddr;
    logic        pwrite;
    logic        psel;
    logic        penable;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic        pready;
    logic        rxd;
    logic        txd;

    int n_tests = 0;
    int n_fail  = 0;
    int cur_div = 16;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    apb_uart uut (
        .pclk(clk), .prst(rst), .paddr(paddr), .pwrite(pwrite), .psel(psel),
        .penable(penable), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .uart_rxd(rxd), .uart_txd(txd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // one transfer; wait state checked every time (R2)
    task automatic apb(input logic wr, input logic [31:0] addr, input logic [31:0] data,
                       output logic [31:0] rd);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = data;
        @(negedge clk);
        penable = 1'b1;
        check("R2 no ready in setup", {31'b0, pready}, 32'd0);
        @(negedge clk);
        check("R2 ready after one wait", {31'b0, pready}, 32'd1);
        rd = prdata;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [31:0] addr, input logic [31:0] data);
        logic [31:0] dummy;
        apb(1'b1, addr, data, dummy);
    endtask

    task automatic rd_check(input string req, input logic [31:0] addr, input logic [31:0] exp);
        logic [31:0] v;
        apb(1'b0, addr, 32'd0, v);
        check(req, v, exp);
    endtask

    // driver: queue the expected frame, then write it (R6)
    task automatic send_tx(input logic [7:0] b);
        exp_q.push_back(b);
        wr(32'h1000_5008, {24'h0, b});
    endtask

    task automatic wait_frame();
        repeat (10 * cur_div + 8) @(negedge clk);
    endtask

    task automatic drive_rx(input logic [7:0] b, input logic stop_bit);
        @(negedge clk);
        rxd = 1'b0;
        repeat (cur_div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (cur_div) @(negedge clk);
        end
        rxd = stop_bit;
        repeat (cur_div) @(negedge clk);
        rxd = 1'b1;
        repeat (cur_div + 4) @(negedge clk);
    endtask

    // monitor: decode frames on the serial output and compare with the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst === 1'b0 && txd === 1'b0) begin
                logic [7:0] got;
                logic       start_ok;
                logic       stop_ok;
                repeat (cur_div / 2) @(negedge clk);
                start_ok = (txd === 1'b0);
                for (int i = 0; i < 8; i++) begin
                    repeat (cur_div) @(negedge clk);
                    got[i] = txd;
                end
                repeat (cur_div) @(negedge clk);
                stop_ok = (txd === 1'b1);
                check("R6 start bit low at centre", {31'b0, start_ok}, 32'd1);
                check("R6 stop bit high", {31'b0, stop_ok}, 32'd1);
                if (exp_q.size() == 0) begin
                    check("R7 unexpected frame", {24'h0, got}, 32'hFFFF_FFFF);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check("R6 frame data", {24'h0, got}, {24'h0, e});
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic stayed_high;
        rst = 1'b1; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0; rxd = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 txd idle high", {31'b0, txd}, 32'd1);
        check("R1 pready low", {31'b0, pready}, 32'd0);
        rd_check("R1 ctrl zero", 32'h1000_5000, 32'd0);
        rd_check("R1 divisor zero", 32'h1000_5004, 32'd0);
        rd_check("R1 tx offset zero", 32'h1000_5008, 32'd0);
        rd_check("R1 rx zero", 32'h1000_500C, 32'd0);

        // R5 divisor, R4 enable
        wr(32'h1000_5004, 32'hABCD_0010);
        rd_check("R5 divisor low 16 bits", 32'h1000_5004, 32'h0000_0010);
        wr(32'h1000_5000, 32'hFFFF_FFFD);
        rd_check("R4 only enable bit kept", 32'h1000_5000, 32'd1);

        // R6 frame, R4 busy flag, R7 write while busy
        send_tx(8'h41);
        rd_check("R4 busy reads back", 32'h1000_5000, 32'd3);
        wr(32'h1000_5008, 32'h0000_0012);
        wait_frame();
        rd_check("R4 busy clears", 32'h1000_5000, 32'd1);
        check("R7 nothing pending", exp_q.size(), 32'd0);

        send_tx(8'hA5); wait_frame();
        send_tx(8'h00); wait_frame();
        send_tx(8'hFF); wait_frame();

        // R5 different bit time
        wr(32'h1000_5004, 32'd8);
        cur_div = 8;
        send_tx(8'h3C); wait_frame();
        check("R5 divisor 8 frame consumed", exp_q.size(), 32'd0);
        wr(32'h1000_5004, 32'd16);
        cur_div = 16;

        // R9 receive, R3 aliases
        drive_rx(8'h5A, 1'b1);
        rd_check("R9 rx byte", 32'h1000_500C, 32'h0000_005A);
        drive_rx(8'hC3, 1'b1);
        rd_check("R3 alias rx read", 32'hFFFF_FF0F, 32'h0000_00C3);
        rd_check("R3 alias divisor read", 32'h2222_2225, 32'd16);

        // R10 glitch rejected
        @(negedge clk);
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * cur_div) @(negedge clk);
        rd_check("R10 glitch ignored", 32'h1000_500C, 32'h0000_00C3);
        drive_rx(8'h96, 1'b1);
        rd_check("R10 next frame received", 32'h1000_500C, 32'h0000_0096);

        // R11 bad stop bit
        drive_rx(8'h11, 1'b0);
        rd_check("R11 framing error dropped", 32'h1000_500C, 32'h0000_0096);

        // R12 unmapped
        rd_check("R12 unmapped read", 32'h1000_5010, 32'd0);
        wr(32'h1000_5014, 32'hFFFF_FFFF);
        wr(32'h1000_501C, 32'h0000_0000);
        rd_check("R12 ctrl unchanged", 32'h1000_5000, 32'd1);
        rd_check("R12 divisor unchanged", 32'h1000_5004, 32'd16);

        // R8 disabled
        wr(32'h1000_5000, 32'd0);
        drive_rx(8'h22, 1'b1);
        rd_check("R8 rx ignored when disabled", 32'h1000_500C, 32'h0000_0096);
        wr(32'h1000_5008, 32'h0000_0077);
        stayed_high = 1'b1;
        for (int i = 0; i < 12 * cur_div; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed_high = 1'b0;
        end
        check("R8 tx idle when disabled", {31'b0, stayed_high}, 32'd1);
        check("R8 scoreboard empty", exp_q.size(), 32'd0);

        finish_run();
    end

endmodule